// File: doc/BRIEF.md
# Thermal Threshold Interrupt Controller

This block watches an 8-bit temperature code from an on-chip sensor. It compares each accepted code against three programmable rising levels and three programmable falling levels. A crossing of any level latches a pending event. A maskable interrupt line is raised from the pending events that are enabled. A fourth rising level is reserved for a hardware thermal trip. Once the trip fires it holds a shutdown output high until reset.

Software reaches the block through a 32-bit word-addressed register port. Register reads are combinational and writes take effect at the clock edge. Software converts degrees to codes before it programs any threshold, so the block works only in code units. A sensor-select field in the control register is driven straight out to choose the sensor channel.

Top module: `tmon_top`

## Requirements
- R1: After reset every register reads zero, and irq, trip and sensor_sel are low. Word addresses are: 0 control, 1 rising thresholds, 2 falling thresholds, 3 interrupt enable, 4 interrupt clear, 5 pending status, 6 current code. Address 7 reads zero.
- R2: Control bits: bit 0 is core enable, bit 12 is trip enable, bits 23:20 are the sensor select. Other control bits read zero. The enable register keeps only bits 0, 4, 8, 16, 20 and 24. The threshold registers keep all 32 bits. The clear register reads zero. Writes to addresses 5 and 6 have no effect.
- R3: A code is accepted when sensor_valid is high and core enable is set. The accepted code reads back at address 6, bits 7:0, after the clock edge. With core enable clear, or with sensor_valid low, codes are ignored: the current code stays the same and no event is latched.
- R4: Level i (0 to 2) compares against byte i of the rising register (bits 8i+7:8i). A rising event for level i sets status bit 4i. It sets when the accepted code is at or above that byte and the previously accepted code was below it. The previous code is zero after reset.
- R5: A falling event for level i sets status bit 16+4i. It sets when the accepted code is below byte i of the falling register and the previous code was at or above it. A falling threshold of zero never produces an event.
- R6: Events are latched in the status register whatever the enable bits are. irq is high exactly while some status bit and its matching enable bit are both set.
- R7: Writing a one to a position of the clear register clears that status bit after the edge. Other bits are untouched. If a new event for a bit arrives in the same cycle as its clear, the bit stays set.
- R8: When core enable and trip enable are both set, an accepted code at or above byte 3 of the rising register (bits 31:24) sets trip after the edge. trip then stays high until reset, even if trip enable is later cleared. It does not depend on the interrupt enables.
- R9: sensor_sel always equals control bits 23:20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sensor_code | input | 8 | Temperature code from the sensor |
| sensor_valid | input | 1 | Marks sensor_code as a new sample |
| sensor_sel | output | 4 | Sensor channel select |
| irq | output | 1 | Enabled pending-event interrupt |
| trip | output | 1 | Sticky hardware thermal trip |

## Verification
Two functions can act on the same status bit in one cycle: a newly detected crossing and a software clear. The bench provokes this by driving a code that crosses rising level 0 in the same cycle as a clear write. That write targets both the rising-0 bit and an already pending falling-0 bit. It passes only if the rising bit survives and the falling bit is gone. The table walk also brings several levels across in one sample, in both directions. Every bit that those crossings should set is compared against the status read-back.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int REG_W      = 32;
  localparam int CODE_W     = 8;
  localparam int NUM_LVL    = 3;
  localparam int LVL_STRIDE = 4;
  localparam int FALL_BASE  = 16;
  localparam int ADDR_W     = 3;
  localparam int SEL_W      = 4;
  localparam int SEL_LSB    = 20;
  localparam int CORE_BIT   = 0;
  localparam int TRIPEN_BIT = 12;
  localparam int TRIP_LVL   = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_RISE = 3'd1;
  localparam logic [ADDR_W-1:0] A_FALL = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ICLR = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;
  localparam logic [ADDR_W-1:0] A_TEMP = 3'd6;

  // status / enable / clear bit position of a rising level
  function automatic int rise_pos(input int lvl);
    return lvl * LVL_STRIDE;
  endfunction

  // status / enable / clear bit position of a falling level
  function automatic int fall_pos(input int lvl);
    return FALL_BASE + lvl * LVL_STRIDE;
  endfunction

  // all implemented event bit positions
  function automatic logic [REG_W-1:0] event_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      m[rise_pos(i)] = 1'b1;
      m[fall_pos(i)] = 1'b1;
    end
    return m;
  endfunction

  // implemented control bits
  function automatic logic [REG_W-1:0] ctrl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[CORE_BIT]   = 1'b1;
    m[TRIPEN_BIT] = 1'b1;
    for (int i = 0; i < SEL_W; i++) m[SEL_LSB + i] = 1'b1;
    return m;
  endfunction

  // upward crossing: now at/above, before below
  function automatic logic went_up(input logic [CODE_W-1:0] now_c,
                                   input logic [CODE_W-1:0] old_c,
                                   input logic [CODE_W-1:0] thr);
    return (now_c >= thr) && (old_c < thr);
  endfunction

  // downward crossing: now below, before at/above
  function automatic logic went_down(input logic [CODE_W-1:0] now_c,
                                     input logic [CODE_W-1:0] old_c,
                                     input logic [CODE_W-1:0] thr);
    return (now_c < thr) && (old_c >= thr);
  endfunction
endpackage

// File: rtl/tmon_regfile.sv
module tmon_regfile
  import tmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [REG_W-1:0]  rise_thr_q,
  output logic [REG_W-1:0]  fall_thr_q,
  output logic [REG_W-1:0]  ien_q,
  output logic [REG_W-1:0]  clr_vec
);
  localparam logic [REG_W-1:0] CTRL_MASK = ctrl_mask();
  localparam logic [REG_W-1:0] EVT_MASK  = event_mask();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      rise_thr_q <= '0;
      fall_thr_q <= '0;
      ien_q      <= '0;
    end else if (wen) begin
      case (addr)
        A_CTRL:  ctrl_q     <= wdata & CTRL_MASK;
        A_RISE:  rise_thr_q <= wdata;
        A_FALL:  fall_thr_q <= wdata;
        A_IEN:   ien_q      <= wdata & EVT_MASK;
        default: ;
      endcase
    end
  end

  // write-one-to-clear pulse, valid only during the write cycle
  assign clr_vec = (wen && addr == A_ICLR) ? (wdata & EVT_MASK) : '0;
endmodule

// File: rtl/tmon_level_det.sv
module tmon_level_det
  import tmon_pkg::*;
#(
  parameter int LVLS = NUM_LVL
)(
  input  logic                     accept,
  input  logic [CODE_W-1:0]        code,
  input  logic [CODE_W-1:0]        prev,
  input  logic [LVLS*CODE_W-1:0]   rise_thr,
  input  logic [LVLS*CODE_W-1:0]   fall_thr,
  output logic [LVLS-1:0]          rise_hit,
  output logic [LVLS-1:0]          fall_hit,
  output logic [REG_W-1:0]         set_vec
);
  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    logic [CODE_W-1:0] r_thr;
    logic [CODE_W-1:0] f_thr;
    assign r_thr       = rise_thr[g*CODE_W +: CODE_W];
    assign f_thr       = fall_thr[g*CODE_W +: CODE_W];
    assign rise_hit[g] = accept && went_up(code, prev, r_thr);
    assign fall_hit[g] = accept && went_down(code, prev, f_thr);
  end

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < LVLS; i++) begin
      set_vec[rise_pos(i)] = rise_hit[i];
      set_vec[fall_pos(i)] = fall_hit[i];
    end
  end
endmodule

// File: rtl/tmon_event_bank.sv
module tmon_event_bank
  import tmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  input  logic [REG_W-1:0] ien,
  output logic [REG_W-1:0] pending_q,
  output logic             irq
);
  logic [REG_W-1:0] pending_d;

  // new events take priority over a clear in the same cycle
  assign pending_d = (pending_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= '0;
    else        pending_q <= pending_d;
  end

  assign irq = |(pending_q & ien);
endmodule

// File: rtl/tmon_top.sv
module tmon_top
  import tmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [CODE_W-1:0] sensor_code,
  input  logic              sensor_valid,
  output logic [SEL_W-1:0]  sensor_sel,
  output logic              irq,
  output logic              trip
);
  localparam int LVL_BITS = NUM_LVL * CODE_W;

  logic [REG_W-1:0]   ctrl_q, rise_thr_q, fall_thr_q, ien_q, clr_vec;
  logic [REG_W-1:0]   set_vec, pending_q;
  logic [NUM_LVL-1:0] rise_hit, fall_hit;
  logic [CODE_W-1:0]  cur_code_q;
  logic [CODE_W-1:0]  trip_thr;
  logic               core_en, trip_en, accept, trip_hit, trip_q;

  tmon_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wen        (reg_wen),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .ctrl_q     (ctrl_q),
    .rise_thr_q (rise_thr_q),
    .fall_thr_q (fall_thr_q),
    .ien_q      (ien_q),
    .clr_vec    (clr_vec)
  );

  assign core_en    = ctrl_q[CORE_BIT];
  assign trip_en    = ctrl_q[TRIPEN_BIT];
  assign sensor_sel = ctrl_q[SEL_LSB +: SEL_W];
  assign accept     = sensor_valid && core_en;
  assign trip_thr   = rise_thr_q[TRIP_LVL*CODE_W +: CODE_W];

  tmon_level_det #(.LVLS(NUM_LVL)) u_det (
    .accept   (accept),
    .code     (sensor_code),
    .prev     (cur_code_q),
    .rise_thr (rise_thr_q[LVL_BITS-1:0]),
    .fall_thr (fall_thr_q[LVL_BITS-1:0]),
    .rise_hit (rise_hit),
    .fall_hit (fall_hit),
    .set_vec  (set_vec)
  );

  tmon_event_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .ien       (ien_q),
    .pending_q (pending_q),
    .irq       (irq)
  );

  // the last accepted code doubles as the "previous" code for crossings
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_code_q <= '0;
    else if (accept) cur_code_q <= sensor_code;
  end

  assign trip_hit = accept && trip_en && (sensor_code >= trip_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trip_q <= 1'b0;
    else if (trip_hit) trip_q <= 1'b1;
  end

  assign trip = trip_q;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_RISE:  reg_rdata = rise_thr_q;
      A_FALL:  reg_rdata = fall_thr_q;
      A_IEN:   reg_rdata = ien_q;
      A_STAT:  reg_rdata = pending_q;
      A_TEMP:  reg_rdata = {{(REG_W-CODE_W){1'b0}}, cur_code_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmon_checker.sv
module tmon_checker
  import tmon_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic               trip,
  input logic               core_en,
  input logic               trip_en,
  input logic               accept,
  input logic [CODE_W-1:0]  sensor_code,
  input logic [CODE_W-1:0]  cur_code,
  input logic [CODE_W-1:0]  trip_thr,
  input logic [REG_W-1:0]   set_vec,
  input logic [REG_W-1:0]   clr_vec,
  input logic [REG_W-1:0]   pending,
  input logic [CODE_W-1:0]  fall_thr0,
  input logic [NUM_LVL-1:0] fall_hit
);
  a_r8_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> trip);

  a_r8_trip_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> $past(accept && trip_en && (sensor_code >= trip_thr)));

  a_r3_code_held_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> $stable(cur_code));

  a_r3_no_event_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> (set_vec == '0));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pending & $past(set_vec)) == $past(set_vec)));

  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((pending & $past(clr_vec & ~set_vec)) == '0));

  a_r6_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pending != '0));

  a_r5_zero_fall_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_thr0 == '0) |-> !fall_hit[0]);
endmodule

bind tmon_top tmon_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq         (irq),
  .trip        (trip),
  .core_en     (core_en),
  .trip_en     (trip_en),
  .accept      (accept),
  .sensor_code (sensor_code),
  .cur_code    (cur_code_q),
  .trip_thr    (trip_thr),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec),
  .pending     (pending_q),
  .fall_thr0   (fall_thr_q[7:0]),
  .fall_hit    (fall_hit)
);

// File: tb/tmon_top_test.sv
module tmon_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;
  localparam logic [31:0] CLR_ALL = 32'h0111_0111;

  // {code, expected status after the sample}; rise 60/80/100, fall 50/70/90
  localparam logic [39:0] VEC [0:13] = '{
    {8'd30,  32'h0000_0000},
    {8'd65,  32'h0000_0001},
    {8'd85,  32'h0000_0010},
    {8'd105, 32'h0000_0100},
    {8'd95,  32'h0000_0000},
    {8'd85,  32'h0100_0000},
    {8'd40,  32'h0011_0000},
    {8'd110, 32'h0000_0111},
    {8'd112, 32'h0000_0000},
    {8'd20,  32'h0111_0000},
    {8'd60,  32'h0000_0001},
    {8'd59,  32'h0000_0000},
    {8'd50,  32'h0000_0000},
    {8'd49,  32'h0001_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  sensor_code = '0;
  logic        sensor_valid = 1'b0;
  logic [3:0]  sensor_sel;
  logic        irq, trip;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  tmon_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sensor_code(sensor_code),
    .sensor_valid(sensor_valid), .sensor_sel(sensor_sel), .irq(irq), .trip(trip)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push(input logic [7:0] c);
    @(negedge clk);
    sensor_code = c; sensor_valid = 1'b1;
    @(negedge clk);
    sensor_valid = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 trip", {31'b0, trip}, 32'h0);
    check("R1 sensor_sel", {28'b0, sensor_sel}, 32'h0);

    // R2 / R9: register read-back and masks
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R2 ctrl mask", d, 32'h00F0_1001);
    check("R9 sel all ones", {28'b0, sensor_sel}, 32'hF);
    wr(3'd0, 32'h0030_0001);
    check("R9 sel three", {28'b0, sensor_sel}, 32'h3);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); check("R2 enable mask", d, CLR_ALL);
    wr(3'd3, 32'h0);
    wr(3'd1, 32'h7864_503C);
    rd(3'd1, d); check("R2 rise thr", d, 32'h7864_503C);
    wr(3'd2, 32'h005A_4632);
    rd(3'd2, d); check("R2 fall thr", d, 32'h005A_4632);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); check("R2 clear reads zero", d, 32'h0);
    wr(3'd6, 32'h0000_00FF);
    rd(3'd6, d); check("R2 temp write ignored", d, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); check("R2 status write ignored", d, 32'h0);

    // R4 / R5 / R6: table walk, enables all zero
    for (int i = 0; i < 14; i++) begin
      push(VEC[i][39:32]);
      rd(3'd5, d); check("R4/R5 status", d, VEC[i][31:0]);
      rd(3'd6, d); check("R3 current code", d, {24'b0, VEC[i][39:32]});
      check("R6 irq masked", {31'b0, irq}, 32'h0);
      wr(3'd4, CLR_ALL);
    end

    // R3: ignored codes (core off, then valid low)
    wr(3'd0, 32'h0030_0000);
    push(8'd110);
    rd(3'd6, d); check("R3 core off code", d, 32'd49);
    rd(3'd5, d); check("R3 core off events", d, 32'h0);
    wr(3'd0, 32'h0030_0001);
    @(negedge clk); sensor_code = 8'd110;
    @(negedge clk); #1;
    rd(3'd6, d); check("R3 valid low code", d, 32'd49);
    rd(3'd5, d); check("R3 valid low events", d, 32'h0);

    // R6: interrupt masking
    push(8'd65);
    rd(3'd5, d); check("R6 latched unmasked", d, 32'h1);
    check("R6 irq off", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h1);
    check("R6 irq on", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'h10);
    check("R6 other enable", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h1);
    wr(3'd4, 32'h1);
    check("R7 clear drops irq", {31'b0, irq}, 32'h0);
    rd(3'd5, d); check("R7 cleared", d, 32'h0);
    wr(3'd3, 32'h0);

    // R7: event and clear of the same bit in one cycle
    push(8'd20);
    rd(3'd5, d); check("R5 fall0 pending", d, 32'h0001_0000);
    @(negedge clk);
    sensor_code = 8'd70; sensor_valid = 1'b1;
    reg_addr = 3'd4; reg_wdata = 32'h0001_0001; reg_wen = 1'b1;
    @(negedge clk);
    sensor_valid = 1'b0; reg_wen = 1'b0;
    rd(3'd5, d); check("R7 set wins over clear", d, 32'h0000_0001);
    wr(3'd4, CLR_ALL);

    // R8: hardware trip
    push(8'd125);
    check("R8 no trip when disabled", {31'b0, trip}, 32'h0);
    wr(3'd0, 32'h0030_1001);
    push(8'd119);
    check("R8 below trip level", {31'b0, trip}, 32'h0);
    push(8'd120);
    check("R8 trip at level", {31'b0, trip}, 32'h1);
    check("R8 irq independent", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h0030_0001);
    push(8'd10);
    check("R8 trip sticky", {31'b0, trip}, 32'h1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    check("R8 trip cleared by reset", {31'b0, trip}, 32'h0);
    rst_n = 1'b1;
    rd(3'd1, d); check("R1 thr after reset", d, 32'h0);

    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule